// File: doc/BRIEF.md
# I2C Register Target with Selectable Pointer Modes

This block is a legacy I2C target that answers at one configured 7-bit address and holds its data in an internal store of 32-bit words addressed byte by byte through an 8-bit pointer. It sees SCL and SDA as already synchronised samples on the system clock. It controls the bus only through an open-drain enable that pulls SDA low. START, repeated START and STOP are decoded from the sampled lines. The target acknowledges its own address, accepts write bytes, and returns read bytes most significant bit first.

A run-time mode input decides what the first write byte means and how the pointer moves between data bytes. In the flat mode there is no sub-address and every byte goes to one fixed location. In the four sub-address modes the first write byte is a sub-address: it either loads the pointer (hold, step, ring) or is acknowledged and dropped (skip). Between bytes the pointer stays put (hold), counts up and stops at the top (step), or counts up and wraps (ring). A read that follows a repeated START picks up the pointer left by the preceding write and moves it under the same rules.

Top module: `i2c_subaddr_target`

## Requirements
- R1: The target acknowledges by pulling SDA low during the ninth clock of the address byte only when the seven address bits equal `cfg_addr_i` and `cfg_addr_i` lies in 0x08..0x77. Otherwise SDA stays released for the rest of that transfer and the store is untouched.
- R2: SDA falling while SCL is high (START or repeated START) and SDA rising while SCL is high (STOP) reset the bit and byte state at any point, discarding any partial byte. After either one, SDA is released.
- R3: Once addressed for a write (address byte bit 0 = 0), the target acknowledges every following byte.
- R4: In modes 1, 2 and 3, the first byte after a write address loads the 8-bit pointer, and later bytes are data.
- R5: In mode 0 (and for the unused codes 5..7) there is no sub-address. Every written byte goes to byte location 0x00, and every read byte comes from 0x00.
- R6: In mode 1 (hold), the pointer does not move between data bytes of reads or writes.
- R7: In mode 2 (step), the pointer advances by one after each data byte and saturates at 0xFF.
- R8: In mode 3 (ring), the pointer advances by one after each data byte and wraps from 0xFF to 0x00.
- R9: In mode 4 (skip), the sub-address byte is acknowledged but leaves the pointer and the store unchanged. Data bytes go to location 0x00.
- R10: Byte address a lives in word a[7:2], lane a[1:0] of a 64 x 32-bit store. A write changes only the addressed byte.
- R11: When the target is addressed for a read (bit 0 = 1), it drives each bit while SCL is low and holds it through SCL high. After a controller ACK it sends the next byte. After a controller NACK it releases SDA until the next START or STOP.
- R12: The pointer keeps its value across repeated START and STOP, so a read starts from the pointer left by the last write.
- R13: After reset, SDA is released, every stored byte reads 0x00, and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised SCL sample |
| sda_i | input | 1 | Synchronised SDA sample |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_addr_i | input | 7 | Static target address |
| cfg_mode_i | input | 3 | Pointer mode: 0 flat, 1 hold, 2 step, 3 ring, 4 skip |

## Verification
Completing a received data byte commits the byte to the store and steps the pointer in the same clock. The write must use the old pointer value, and the step must obey the mode's boundary rule. The bench provokes this with bursts that begin at 0xFE in step and ring modes, and with hold and skip bursts. It judges the result by reading the bytes back through the bus against a behavioural byte-array model. A second collision, a START arriving in the middle of a byte, is provoked by cutting a data byte after four bits. The bench then checks that the partial byte left no trace.

// File: rtl/i2ct_pkg.sv
// Package: shared encodings for the I2C register target.
// Holds the pointer-mode codes, the link state type and small decode helpers.
package i2ct_pkg;

    typedef enum logic [2:0] {
        MODE_FLAT = 3'd0,
        MODE_HOLD = 3'd1,
        MODE_STEP = 3'd2,
        MODE_RING = 3'd3,
        MODE_SKIP = 3'd4
    } ptr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_TACK,
        ST_WAIT
    } link_st_e;

    // True when the first write byte is a sub-address byte.
    function automatic logic mode_has_sub(input logic [2:0] m);
        return (m == MODE_HOLD) || (m == MODE_STEP) ||
               (m == MODE_RING) || (m == MODE_SKIP);
    endfunction

    // True when the sub-address byte loads the pointer.
    function automatic logic mode_uses_ptr(input logic [2:0] m);
        return (m == MODE_HOLD) || (m == MODE_STEP) || (m == MODE_RING);
    endfunction

endpackage

// File: rtl/i2ct_bus_cond.sv
// Module: i2ct_bus_cond
// Turns synchronised SCL/SDA samples into single-cycle edge and
// bus-condition pulses. Assumes inputs are already free of metastability
// and that SCL is several system clocks per phase.
module i2ct_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    // Derive edges and START/STOP from current versus previous sample.
    always_comb begin
        scl_rise_o = scl_i & ~scl_q;
        scl_fall_o = ~scl_i & scl_q;
        start_o    = scl_i & scl_q & sda_q & ~sda_i;
        stop_o     = scl_i & scl_q & ~sda_q & sda_i;
    end

endmodule

// File: rtl/i2ct_ptr_unit.sv
// Module: i2ct_ptr_unit
// Holds the byte pointer and applies the mode rules: load from a
// sub-address byte, step with saturation or wrap, or stay fixed.
// In modes without a pointer the output is the fixed location.
module i2ct_ptr_unit
    import i2ct_pkg::*;
#(
    parameter int unsigned SUB_W     = 8,
    parameter logic [SUB_W-1:0] FIXED_LOC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode_i,
    input  logic             load_i,
    input  logic [SUB_W-1:0] load_val_i,
    input  logic             step_i,
    output logic [SUB_W-1:0] byte_addr_o
);

    localparam logic [SUB_W-1:0] PTR_TOP = '1;

    logic [SUB_W-1:0] ptr_q;

    // Update the pointer on a load or a step, per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (load_i) begin
            ptr_q <= load_val_i;
        end else if (step_i) begin
            if (mode_i == MODE_STEP) begin
                if (ptr_q != PTR_TOP) ptr_q <= ptr_q + 1'b1;
            end else if (mode_i == MODE_RING) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    // Select the effective byte address.
    always_comb begin
        byte_addr_o = mode_uses_ptr(mode_i) ? ptr_q : FIXED_LOC;
    end

endmodule

// File: rtl/i2ct_byte_store.sv
// Module: i2ct_byte_store
// Word-organised flop store with byte-lane writes and a combinational
// byte read. The byte address splits into word index (upper bits) and
// lane (lower bits). All bytes clear on reset.
module i2ct_byte_store #(
    parameter int unsigned SUB_W  = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [SUB_W-1:0] addr_i,
    input  logic [7:0]       wdata_i,
    output logic [7:0]       rdata_o
);

    localparam int unsigned LANES  = WORD_W / 8;
    localparam int unsigned LANE_W = $clog2(LANES);
    localparam int unsigned IDX_W  = SUB_W - LANE_W;
    localparam int unsigned DEPTH  = 1 << IDX_W;

    logic [WORD_W-1:0] words_q [DEPTH];
    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] lane;
    logic [DEPTH-1:0]  word_sel;
    logic [LANES-1:0]  lane_sel;

    assign idx  = addr_i[SUB_W-1:LANE_W];
    assign lane = addr_i[LANE_W-1:0];

    // Per-word and per-lane select decode.
    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        assign word_sel[w] = (idx == IDX_W'(w));
    end
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_sel[l] = (lane == LANE_W'(l));
    end

    // Clear on reset, otherwise write the one selected byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) words_q[w] <= '0;
        end else if (we_i) begin
            for (int w = 0; w < DEPTH; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (word_sel[w] && lane_sel[l]) words_q[w][l*8 +: 8] <= wdata_i;
                end
            end
        end
    end

    // Read the addressed byte.
    always_comb begin
        rdata_o = words_q[idx][lane*8 +: 8];
    end

endmodule

// File: rtl/i2ct_link.sv
// Module: i2ct_link
// Bit and byte engine of the target: shifts address and data on SCL
// rising edges, changes SDA only after SCL falling edges, and produces
// store-write, pointer-load and pointer-step strobes. Assumes no clock
// stretching and 7-bit addressing only.
module i2ct_link
    import i2ct_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter logic [ADDR_W-1:0] LEGAL_LO = 7'h08,
    parameter logic [ADDR_W-1:0] LEGAL_HI = 7'h77
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [2:0]        mode_i,
    input  logic [7:0]        rdata_i,
    output logic              sda_oe_o,
    output logic              we_o,
    output logic [7:0]        wdata_o,
    output logic              load_o,
    output logic [7:0]        load_val_o,
    output logic              step_o
);

    link_st_e   st_q;
    logic [3:0] bit_cnt_q;
    logic [7:0] rx_sh_q;
    logic [7:0] tx_sh_q;
    logic       rd_q;
    logic       first_q;
    logic       mack_q;

    logic addr_hit;
    logic rx_done;
    logic tx_done;
    logic sub_byte;

    // Address comparison against the configured, legal address.
    always_comb begin
        addr_hit = (rx_sh_q[7:1] == cfg_addr_i) &&
                   (cfg_addr_i >= LEGAL_LO) && (cfg_addr_i <= LEGAL_HI);
    end

    // Main bit/byte state machine; START and STOP win over everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= ST_IDLE;
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            rd_q      <= 1'b0;
            first_q   <= 1'b0;
            mack_q    <= 1'b0;
        end else if (start_i) begin
            st_q      <= ST_ADDR;
            bit_cnt_q <= '0;
        end else if (stop_i) begin
            st_q      <= ST_IDLE;
            bit_cnt_q <= '0;
        end else begin
            case (st_q)
                ST_ADDR, ST_RX: begin
                    if (scl_rise_i && bit_cnt_q != 4'd8) begin
                        rx_sh_q   <= {rx_sh_q[6:0], sda_i};
                        bit_cnt_q <= bit_cnt_q + 4'd1;
                    end else if (scl_fall_i && bit_cnt_q == 4'd8) begin
                        if (st_q == ST_RX) begin
                            st_q    <= ST_RACK;
                            first_q <= 1'b0;
                        end else if (addr_hit) begin
                            st_q <= ST_AACK;
                            rd_q <= rx_sh_q[0];
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall_i) begin
                        bit_cnt_q <= '0;
                        if (rd_q) begin
                            tx_sh_q <= rdata_i;
                            st_q    <= ST_TX;
                        end else begin
                            first_q <= 1'b1;
                            st_q    <= ST_RX;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_fall_i) begin
                        bit_cnt_q <= '0;
                        st_q      <= ST_RX;
                    end
                end
                ST_TX: begin
                    if (scl_fall_i) begin
                        if (bit_cnt_q == 4'd7) begin
                            st_q <= ST_TACK;
                        end else begin
                            tx_sh_q   <= {tx_sh_q[6:0], 1'b0};
                            bit_cnt_q <= bit_cnt_q + 4'd1;
                        end
                    end
                end
                ST_TACK: begin
                    if (scl_rise_i) begin
                        mack_q <= ~sda_i;
                    end else if (scl_fall_i) begin
                        if (mack_q) begin
                            tx_sh_q   <= rdata_i;
                            bit_cnt_q <= '0;
                            st_q      <= ST_TX;
                        end else begin
                            st_q <= ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Byte-completion strobes and open-drain drive.
    always_comb begin
        rx_done    = (st_q == ST_RX) && scl_fall_i && (bit_cnt_q == 4'd8) &&
                     !start_i && !stop_i;
        tx_done    = (st_q == ST_TX) && scl_fall_i && (bit_cnt_q == 4'd7) &&
                     !start_i && !stop_i;
        sub_byte   = rx_done && first_q && mode_has_sub(mode_i);
        load_o     = sub_byte && mode_uses_ptr(mode_i);
        load_val_o = rx_sh_q;
        we_o       = rx_done && !sub_byte;
        wdata_o    = rx_sh_q;
        step_o     = (rx_done && !sub_byte) || tx_done;
        sda_oe_o   = (st_q == ST_AACK) || (st_q == ST_RACK) ||
                     ((st_q == ST_TX) && !tx_sh_q[7]);
    end

endmodule

// File: rtl/i2c_subaddr_target.sv
// Module: i2c_subaddr_target
// Top of the I2C register target: bus-condition decode, link engine,
// pointer unit and byte store. Assumes synchronised SCL/SDA inputs and
// configuration that changes only while the bus is idle.
module i2c_subaddr_target
    import i2ct_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned SUB_W  = 8,
    parameter int unsigned WORD_W = 32,
    parameter logic [ADDR_W-1:0] LEGAL_LO = 7'h08,
    parameter logic [ADDR_W-1:0] LEGAL_HI = 7'h77,
    parameter logic [SUB_W-1:0]  FIXED_LOC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [ADDR_W-1:0] cfg_addr_i,
    input  logic [2:0]        cfg_mode_i
);

    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             we;
    logic [7:0]       wdata;
    logic             ptr_load;
    logic [7:0]       ptr_load_val;
    logic             ptr_step;
    logic [SUB_W-1:0] byte_addr;
    logic [7:0]       rdata;

    i2ct_bus_cond u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    i2ct_link #(
        .ADDR_W   (ADDR_W),
        .LEGAL_LO (LEGAL_LO),
        .LEGAL_HI (LEGAL_HI)
    ) u_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .sda_i      (sda_i),
        .cfg_addr_i (cfg_addr_i),
        .mode_i     (cfg_mode_i),
        .rdata_i    (rdata),
        .sda_oe_o   (sda_oe_o),
        .we_o       (we),
        .wdata_o    (wdata),
        .load_o     (ptr_load),
        .load_val_o (ptr_load_val),
        .step_o     (ptr_step)
    );

    i2ct_ptr_unit #(
        .SUB_W     (SUB_W),
        .FIXED_LOC (FIXED_LOC)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_i      (cfg_mode_i),
        .load_i      (ptr_load),
        .load_val_i  (SUB_W'(ptr_load_val)),
        .step_i      (ptr_step),
        .byte_addr_o (byte_addr)
    );

    i2ct_byte_store #(
        .SUB_W  (SUB_W),
        .WORD_W (WORD_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we),
        .addr_i  (byte_addr),
        .wdata_i (wdata),
        .rdata_o (rdata)
    );

endmodule

// File: rtl/i2ct_chk.sv
// Module: i2ct_chk
// Bus-level property checker for the I2C register target, attached by
// bind. Observes only the top-level ports.
module i2ct_chk #(
    parameter int unsigned ADDR_W = 7,
    parameter logic [ADDR_W-1:0] LEGAL_LO = 7'h08,
    parameter logic [ADDR_W-1:0] LEGAL_HI = 7'h77
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_i,
    input logic              sda_oe_o,
    input logic [ADDR_W-1:0] cfg_addr_i
);

    logic addr_bad;
    assign addr_bad = (cfg_addr_i < LEGAL_LO) || (cfg_addr_i > LEGAL_HI);

    // R2: a STOP leaves SDA released on the next cycle.
    a_r2_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe_o);

    // R2: a START leaves SDA released on the next cycle.
    a_r2_release_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i) && !sda_i && $past(sda_i)) |=> !sda_oe_o);

    // R11: the target never changes SDA while SCL stays high.
    a_r11_sda_changes_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    // R1: with an illegal configured address the target stays silent.
    a_r1_illegal_addr_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_bad && $past(addr_bad)) |-> !sda_oe_o);

    // R13: SDA is released on leaving reset.
    a_r13_released_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sda_oe_o);

endmodule

bind i2c_subaddr_target i2ct_chk #(
    .ADDR_W   (ADDR_W),
    .LEGAL_LO (LEGAL_LO),
    .LEGAL_HI (LEGAL_HI)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_oe_o   (sda_oe_o),
    .cfg_addr_i (cfg_addr_i)
);

// File: tb/i2c_subaddr_target_tb_top.sv
`timescale 1ns/1ps
// Bench: drives I2C transfers bit by bit, keeps a behavioural byte-array
// and pointer model, compares the SDA drive every clock and read data per byte.
module i2c_subaddr_target_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_drv = 1'b1;
    logic       sda_oe;
    logic [6:0] cfg_addr = 7'h3A;
    logic [2:0] cfg_mode = 3'd2;
    wire        bus_sda = sda_drv & ~sda_oe;

    int         vectors = 0;
    int         miscompares = 0;
    logic       cmp_on = 1'b0;
    logic       exp_oe = 1'b0;
    string      cur_tag = "R13";

    logic [7:0] model_mem [256];
    int         model_ptr = 0;

    always #2.5 clk = ~clk;

    i2c_subaddr_target dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (bus_sda),
        .sda_oe_o   (sda_oe),
        .cfg_addr_i (cfg_addr),
        .cfg_mode_i (cfg_mode)
    );

    // Per-clock comparison of the SDA drive against the model expectation.
    always @(negedge clk) begin
        #1;
        if (cmp_on && rst_n) begin
            vectors++;
            if (sda_oe !== exp_oe) begin
                miscompares++;
                $display("FAIL %s sda_oe got=%0b exp=%0b at %0t", cur_tag, sda_oe, exp_oe, $time);
            end
        end
    end

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
        end
    endtask

    // Model helpers.
    function automatic int model_loc();
        return (cfg_mode inside {3'd1, 3'd2, 3'd3}) ? model_ptr : 0;
    endfunction

    function automatic void model_adv();
        if (cfg_mode == 3'd2 && model_ptr != 255) model_ptr++;
        else if (cfg_mode == 3'd3) model_ptr = (model_ptr + 1) % 256;
    endfunction

    function automatic bit model_hit(input logic [6:0] a);
        return (a == cfg_addr) && (cfg_addr >= 7'h08) && (cfg_addr <= 7'h77);
    endfunction

    // One SCL period: low phase (drive), then high phase (sample).
    task automatic bit_cycle(input logic drv, input logic eo, output logic smp);
        @(negedge clk); cmp_on = 1'b0; scl = 1'b0;
        @(negedge clk); sda_drv = drv; exp_oe = eo; cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        smp = bus_sda;
    endtask

    task automatic do_start();
        @(negedge clk); cmp_on = 1'b0; scl = 1'b0;
        @(negedge clk); sda_drv = 1'b1; exp_oe = 1'b0; cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        sda_drv = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_stop();
        @(negedge clk); cmp_on = 1'b0; scl = 1'b0;
        @(negedge clk); sda_drv = 1'b0; exp_oe = 1'b0; cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        scl = 1'b1;
        repeat (3) @(negedge clk);
        sda_drv = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic s;
        cur_tag = tag;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], 1'b0, s);
        bit_cycle(1'b1, exp_ack, s);
        chk({tag, " ack"}, {7'd0, ~s}, {7'd0, exp_ack});
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic mack, input string tag);
        logic       s;
        logic [7:0] got;
        cur_tag = tag;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, ~exp[i], s);
            got[i] = s;
        end
        bit_cycle(~mack, 1'b0, s);
        chk({tag, " rdata"}, got, exp);
    endtask

    // Write transfer; the model decides what each byte means.
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] bq[$], input string tag);
        bit hit;
        hit = model_hit(a);
        do_start();
        send_byte({a, 1'b0}, hit, tag);
        if (hit) begin
            foreach (bq[k]) begin
                send_byte(bq[k], 1'b1, tag);
                if (k == 0 && cfg_mode inside {3'd1, 3'd2, 3'd3, 3'd4}) begin
                    if (cfg_mode != 3'd4) model_ptr = int'(bq[k]);
                end else begin
                    model_mem[model_loc()] = bq[k];
                    model_adv();
                end
            end
        end
        do_stop();
    endtask

    // Read body after an address byte (no START/STOP).
    task automatic rd_body(input int n, input string tag);
        for (int k = 0; k < n; k++) begin
            recv_byte(model_mem[model_loc()], (k < n - 1), tag);
            model_adv();
        end
    endtask

    task automatic rd_txn(input int n, input string tag);
        do_start();
        send_byte({cfg_addr, 1'b1}, 1'b1, tag);
        rd_body(n, tag);
        do_stop();
    endtask

    // Load pointer with a write, then repeated START and read.
    task automatic ptr_rd(input logic [7:0] sub, input int n, input string tag);
        do_start();
        send_byte({cfg_addr, 1'b0}, 1'b1, tag);
        send_byte(sub, 1'b1, tag);
        if (cfg_mode inside {3'd1, 3'd2, 3'd3}) model_ptr = int'(sub);
        do_start();
        send_byte({cfg_addr, 1'b1}, 1'b1, tag);
        rd_body(n, tag);
        do_stop();
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic s;
        for (int i = 0; i < 256; i++) model_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R13: released after reset, store and pointer clear.
        chk("R13 oe after reset", {7'd0, sda_oe}, 8'h00);
        rd_txn(2, "R13");

        // R4 R7 R3: step burst from 0x10, then read back (R11 R12).
        cfg_mode = 3'd2;
        wr_txn(7'h3A, '{8'h10, 8'hA1, 8'hB2, 8'hC3, 8'hD4}, "R4");
        ptr_rd(8'h10, 4, "R12");
        rd_txn(1, "R11");

        // R7: saturation at 0xFF.
        wr_txn(7'h3A, '{8'hFE, 8'h11, 8'h22, 8'h33}, "R7");
        ptr_rd(8'hFE, 3, "R7");

        // R8: wrap from 0xFF to 0x00.
        cfg_mode = 3'd3;
        wr_txn(7'h3A, '{8'hFE, 8'h5E, 8'h6F, 8'h70, 8'h81}, "R8");
        ptr_rd(8'hFE, 4, "R8");

        // R6: hold keeps one register for writes and reads.
        cfg_mode = 3'd1;
        wr_txn(7'h3A, '{8'h30, 8'h11, 8'h22, 8'h33}, "R6");
        ptr_rd(8'h30, 3, "R6");

        // R10: neighbouring lanes and words untouched.
        cfg_mode = 3'd2;
        ptr_rd(8'h2F, 4, "R10");

        // R5: flat mode and unused code 5.
        cfg_mode = 3'd0;
        wr_txn(7'h3A, '{8'h9C, 8'h4D}, "R5");
        rd_txn(2, "R5");
        cfg_mode = 3'd5;
        wr_txn(7'h3A, '{8'hE7}, "R5");
        rd_txn(2, "R5");

        // R9: skip mode drops the sub-address, pointer kept.
        cfg_mode = 3'd2;
        wr_txn(7'h3A, '{8'h20, 8'h01}, "R9");
        cfg_mode = 3'd4;
        wr_txn(7'h3A, '{8'h55, 8'hA5, 8'h5A}, "R9");
        rd_txn(1, "R9");
        cfg_mode = 3'd2;
        rd_txn(2, "R9");
        ptr_rd(8'h55, 1, "R9");

        // R1: wrong address, then illegal configured address, then low edge.
        wr_txn(7'h3B, '{8'h40, 8'hEE}, "R1");
        cfg_addr = 7'h78;
        wr_txn(7'h78, '{8'h40, 8'hEE}, "R1");
        cfg_addr = 7'h08;
        wr_txn(7'h08, '{8'h42, 8'h77}, "R1");
        ptr_rd(8'h40, 3, "R1");

        // R2: START after four data bits discards the partial byte.
        do_start();
        send_byte({cfg_addr, 1'b0}, 1'b1, "R2");
        send_byte(8'h48, 1'b1, "R2");
        model_ptr = 8'h48;
        cur_tag = "R2";
        for (int i = 0; i < 4; i++) bit_cycle(1'b1, 1'b0, s);
        wr_txn(7'h08, '{8'h49, 8'h5A}, "R2");
        ptr_rd(8'h48, 2, "R2");

        repeat (5) @(negedge clk);
        cmp_on = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule